// File: doc/BRIEF.md
# Quasi-Bidirectional General-Purpose I/O Port

An eight-bit general-purpose port whose pins have no direction setting. Each pin belongs to one output latch bit. A latch bit of 0 pulls the pad low strongly. A latch bit of 1 only holds the pad high through a weak pull-up, so an external device can still drive the pin low. A pin therefore works as an input only while its latch bit holds 1. Software that wants to read a pin must first write a 1 to that bit.

The bus side has three paths:
- a write path that loads the whole latch;
- a bit-operation path that sets, clears or toggles masked latch bits, using the latch (not the pins) as operand;
- two read outputs: one gives the synchronized pin levels, the other gives the latch contents.

Because of this, a pin read and a latch read can differ. When a latch bit rises from 0 to 1, the block also gives a strong pull-up pulse of one clock to that pin, so the rising edge is fast.

Top module: `qbio_port`

## Requirements
- R1: While `rst_n` is low, every latch bit is 1: `latch_rd` is all ones, `pad_weak_up` is all ones, `pad_pull_dn` is all zeros and `pad_strong_up` is all zeros.
- R2: When `bus_wr` is high at a rising clock edge, the latch takes `bus_wdata` at that edge. The new value is visible on `latch_rd` in the following cycle.
- R3: For every bit, `pad_pull_dn` is the inverse of the latch bit and `pad_weak_up` equals it. The two are never high together on the same bit. Both change in the same cycle as the latch.
- R4: `pin_rd` shows `pad_in` as it was sampled two rising edges earlier. The path is a two-flop synchronizer, reset to all ones.
- R5: `latch_rd` returns the latch contents, not the pin levels. Example: a latch bit of 1 whose pad is held low from outside reads 1 on `latch_rd` and 0 on `pin_rd`.
- R6: When `rmw_en` is high and `bus_wr` is low, the latch is updated at the clock edge from the current latch value and `rmw_mask`, according to `rmw_op`:
  - 0: set the masked bits;
  - 1: clear the masked bits;
  - 2: toggle the masked bits;
  - 3: leave the latch unchanged.
  If `bus_wr` and `rmw_en` are high together, `bus_wr` wins.
- R7: `pad_strong_up` is high for exactly one cycle on each bit whose latch went from 0 to 1. The pulse is in the cycle right after the edge that changed the latch. It is never high on any other bit.
- R8: A pin whose latch bit is 0 reads 0 on `pin_rd` (two cycles later), whatever the external source attempts.
- R9: A pin whose latch bit is 1 reads the external level on `pin_rd`: 0 when the outside pulls it low, 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Whole-latch write strobe |
| bus_wdata | input | 8 | Value loaded into the latch on write |
| rmw_en | input | 1 | Bit-operation strobe |
| rmw_op | input | 2 | Bit operation: 0 set, 1 clear, 2 toggle, 3 keep |
| rmw_mask | input | 8 | Bits affected by the bit operation |
| pad_in | input | 8 | Raw pad levels (asynchronous) |
| pin_rd | output | 8 | Synchronized pin levels |
| latch_rd | output | 8 | Latch contents for read-modify-write |
| pad_pull_dn | output | 8 | Strong pull-down enable per pin |
| pad_weak_up | output | 8 | Weak pull-up enable per pin |
| pad_strong_up | output | 8 | One-clock strong pull-up pulse per pin |

## Verification
The bench models the pad as a wired net: a pad is low if the port pulls it down or the outside pulls it low. With this model it targets four corner cases.

- **Latch 1 with the pin held low.** A design that read pins for bit operations would turn such a pin's latch to 0 through a set or toggle of some other bit.
- **Latch 0 with the outside idle.** Here a design with the pull-down polarity reversed would read the pin back as 1.
- **Exactly one cycle of strong pull-up.** A design that pulsed on the wrong transition, held the pulse longer, or pulsed on an already-high bit would be seen on the pads.
- **Write and bit operation together.** The bench issues both in the same cycle, and uses a keep operation, to catch a wrong priority or an op code that alters the latch.

// File: rtl/qbio_pkg.sv
package qbio_pkg;
  typedef enum logic [1:0] {
    BITOP_SET  = 2'd0,
    BITOP_CLR  = 2'd1,
    BITOP_TGL  = 2'd2,
    BITOP_KEEP = 2'd3
  } bitop_e;
endpackage

// File: rtl/qbio_latch.sv
module qbio_latch
  import qbio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_wr,
  input  logic [W-1:0] bus_wdata,
  input  logic         rmw_en,
  input  bitop_e       rmw_op,
  input  logic [W-1:0] rmw_mask,
  output logic [W-1:0] latch_q,
  output logic [W-1:0] rise_pulse
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  // Bit operation: always takes the latch value as its operand.
  function automatic logic [W-1:0] apply_bitop(input logic [W-1:0] cur,
                                               input bitop_e op,
                                               input logic [W-1:0] mask);
    case (op)
      BITOP_SET: apply_bitop = cur | mask;
      BITOP_CLR: apply_bitop = cur & ~mask;
      BITOP_TGL: apply_bitop = cur ^ mask;
      default:   apply_bitop = cur;
    endcase
  endfunction

  // Bits that go from 0 to 1 between the old and new values.
  function automatic logic [W-1:0] rising_bits(input logic [W-1:0] old_v,
                                               input logic [W-1:0] new_v);
    rising_bits = new_v & ~old_v;
  endfunction

  logic         load_ev;
  logic [W-1:0] next_latch;

  assign load_ev = bus_wr | rmw_en;

  always_comb begin
    if (bus_wr)      next_latch = bus_wdata;
    else if (rmw_en) next_latch = apply_bitop(latch_q, rmw_op, rmw_mask);
    else             next_latch = latch_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q    <= ALL_ONES;
      rise_pulse <= '0;
    end else begin
      rise_pulse <= load_ev ? rising_bits(latch_q, next_latch) : '0;
      if (load_ev) latch_q <= next_latch;
    end
  end
endmodule

// File: rtl/qbio_sync.sv
module qbio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  generate
    for (genvar b = 0; b < W; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d_async[b]};
      end
      assign q_sync[b] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/qbio_drive.sv
module qbio_drive #(
  parameter int W = 8
) (
  input  logic [W-1:0] latch_q,
  input  logic [W-1:0] rise_pulse,
  output logic [W-1:0] pull_dn,
  output logic [W-1:0] weak_up,
  output logic [W-1:0] strong_up
);
  // Latch 0: strong low. Latch 1: weak high only.
  assign pull_dn   = ~latch_q;
  assign weak_up   = latch_q;
  assign strong_up = rise_pulse & latch_q;
endmodule

// File: rtl/qbio_port.sv
module qbio_port
  import qbio_pkg::*;
#(
  parameter int W          = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_wr,
  input  logic [W-1:0] bus_wdata,
  input  logic         rmw_en,
  input  logic [1:0]   rmw_op,
  input  logic [W-1:0] rmw_mask,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pin_rd,
  output logic [W-1:0] latch_rd,
  output logic [W-1:0] pad_pull_dn,
  output logic [W-1:0] pad_weak_up,
  output logic [W-1:0] pad_strong_up
);
  logic [W-1:0] latch_q;
  logic [W-1:0] rise_pulse;
  bitop_e       op_sel;

  assign op_sel = bitop_e'(rmw_op);

  qbio_latch #(.W(W)) latch_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .rmw_en(rmw_en), .rmw_op(op_sel), .rmw_mask(rmw_mask),
    .latch_q(latch_q), .rise_pulse(rise_pulse)
  );

  qbio_sync #(.W(W), .STAGES(SYNC_DEPTH)) sync_i (
    .clk(clk), .rst_n(rst_n), .d_async(pad_in), .q_sync(pin_rd)
  );

  qbio_drive #(.W(W)) drive_i (
    .latch_q(latch_q), .rise_pulse(rise_pulse),
    .pull_dn(pad_pull_dn), .weak_up(pad_weak_up), .strong_up(pad_strong_up)
  );

  assign latch_rd = latch_q;
endmodule

// File: rtl/qbio_port_chk.sv
module qbio_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_wr,
  input logic [W-1:0] bus_wdata,
  input logic         rmw_en,
  input logic [1:0]   rmw_op,
  input logic [W-1:0] rmw_mask,
  input logic [W-1:0] pad_in,
  input logic [W-1:0] pin_rd,
  input logic [W-1:0] latch_rd,
  input logic [W-1:0] pad_pull_dn,
  input logic [W-1:0] pad_weak_up,
  input logic [W-1:0] pad_strong_up
);
  logic [1:0] run_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              run_cnt <= '0;
    else if (run_cnt != 2'd3) run_cnt <= run_cnt + 2'd1;
  end

  // R1: reset holds the latch high and the strong pulse off
  always @(negedge clk) begin
    if (!rst_n) begin
      a_reset_state_r1: assert (latch_rd == {W{1'b1}} && pad_strong_up == '0);
    end
  end

  p_write_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> latch_rd == $past(bus_wdata));

  p_drive_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_pull_dn & pad_weak_up) == '0) && ((pad_pull_dn | pad_weak_up) == {W{1'b1}}));

  p_sync_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_cnt >= 2'd2) |-> pin_rd == $past(pad_in, 2));

  p_rmw_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rmw_en && !bus_wr && rmw_op == 2'd3) |=> $stable(latch_rd));

  p_rmw_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rmw_en && !bus_wr && rmw_op == 2'd0) |=> latch_rd == ($past(latch_rd) | $past(rmw_mask)));

  p_strong_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_cnt >= 2'd1) |-> pad_strong_up == (latch_rd & ~$past(latch_rd)));
endmodule

bind qbio_port qbio_port_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
  .rmw_en(rmw_en), .rmw_op(rmw_op), .rmw_mask(rmw_mask), .pad_in(pad_in),
  .pin_rd(pin_rd), .latch_rd(latch_rd), .pad_pull_dn(pad_pull_dn),
  .pad_weak_up(pad_weak_up), .pad_strong_up(pad_strong_up)
);

// File: tb/qbio_port_tb.sv
module qbio_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       rmw_en = 1'b0;
  logic [1:0] rmw_op = 2'd3;
  logic [7:0] rmw_mask = '0;
  logic [7:0] ext_low = '0;
  logic [7:0] pad_in;
  logic [7:0] pin_rd, latch_rd, pad_pull_dn, pad_weak_up, pad_strong_up;

  // Wired pad: low if the port pulls down or the outside pulls low.
  assign pad_in = ~(pad_pull_dn | ext_low);

  always #10 clk = ~clk;

  qbio_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .rmw_en(rmw_en), .rmw_op(rmw_op), .rmw_mask(rmw_mask), .pad_in(pad_in),
    .pin_rd(pin_rd), .latch_rd(latch_rd), .pad_pull_dn(pad_pull_dn),
    .pad_weak_up(pad_weak_up), .pad_strong_up(pad_strong_up)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  logic [7:0] m_latch = 8'hFF;
  logic [7:0] m_pulse = 8'h00;
  logic [7:0] pad_hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_latch = 8'hFF;
      m_pulse = 8'h00;
      pad_hist = {};
    end else begin
      logic [7:0] nxt;
      nxt = m_latch;
      if (bus_wr) nxt = bus_wdata;
      else if (rmw_en) begin
        if (rmw_op == 2'd0)      nxt = m_latch | rmw_mask;
        else if (rmw_op == 2'd1) nxt = m_latch & ~rmw_mask;
        else if (rmw_op == 2'd2) nxt = m_latch ^ rmw_mask;
      end
      m_pulse = nxt & ~m_latch;
      m_latch = nxt;
      pad_hist.push_back(pad_in);
      if (pad_hist.size() > 2) void'(pad_hist.pop_front());
    end
  end

  // Compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (!done) begin
      logic [7:0] exp_pin;
      exp_pin = (pad_hist.size() < 2) ? 8'hFF : pad_hist[0];
      chk("R2/R6 latch_rd", latch_rd, m_latch);
      chk("R3 pad_pull_dn", pad_pull_dn, ~m_latch);
      chk("R3 pad_weak_up", pad_weak_up, m_latch);
      chk("R7 pad_strong_up", pad_strong_up, m_pulse);
      chk("R4 pin_rd", pin_rd, exp_pin);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] v);
    bus_wr = 1'b1; bus_wdata = v; cyc(1); bus_wr = 1'b0;
  endtask

  task automatic bop(input logic [1:0] op, input logic [7:0] m);
    rmw_en = 1'b1; rmw_op = op; rmw_mask = m; cyc(1); rmw_en = 1'b0;
  endtask

  initial begin
    logic [7:0] lfsr;
    cyc(2);
    chk("R1 reset latch", latch_rd, 8'hFF);
    chk("R1 reset pull_dn", pad_pull_dn, 8'h00);
    chk("R1 reset strong", pad_strong_up, 8'h00);
    rst_n = 1'b1;
    cyc(3);
    wr(8'hA5);
    chk("R2 write", latch_rd, 8'hA5);
    cyc(2);
    chk("R8 low latch reads 0", pin_rd, 8'hA5);
    ext_low = 8'hFF; cyc(3);
    chk("R5 pin_rd all low", pin_rd, 8'h00);
    chk("R5 latch_rd unchanged", latch_rd, 8'hA5);
    ext_low = 8'h00;
    wr(8'hFF);
    chk("R7 pulse on rising bits", pad_strong_up, 8'h5A);
    cyc(1);
    chk("R7 pulse one cycle", pad_strong_up, 8'h00);
    ext_low = 8'h0F; cyc(3);
    chk("R9 external low", pin_rd, 8'hF0);
    ext_low = 8'h00; cyc(3);
    chk("R9 external idle", pin_rd, 8'hFF);
    // R6 bit operations use the latch, not the pins
    wr(8'h30);
    ext_low = 8'h20; cyc(2);
    bop(2'd0, 8'h0F);
    chk("R6 set", latch_rd, 8'h3F);
    bop(2'd1, 8'h30);
    chk("R6 clear", latch_rd, 8'h0F);
    bop(2'd2, 8'hFF);
    chk("R6 toggle", latch_rd, 8'hF0);
    bop(2'd3, 8'hFF);
    chk("R6 keep", latch_rd, 8'hF0);
    bus_wr = 1'b1; bus_wdata = 8'h66; rmw_en = 1'b1; rmw_op = 2'd0; rmw_mask = 8'hFF;
    cyc(1);
    bus_wr = 1'b0; rmw_en = 1'b0;
    chk("R6 write wins", latch_rd, 8'h66);
    ext_low = 8'h00;
    // Mixed traffic, checked by the per-cycle model
    lfsr = 8'h5D;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      bus_wr   = (lfsr[1:0] == 2'b00);
      bus_wdata = lfsr ^ 8'h3C;
      rmw_en   = lfsr[2];
      rmw_op   = lfsr[4:3];
      rmw_mask = {lfsr[3:0], lfsr[7:4]};
      ext_low  = lfsr[6] ? (lfsr & 8'h93) : 8'h00;
      cyc(1);
    end
    bus_wr = 1'b0; rmw_en = 1'b0; ext_low = 8'h00;
    cyc(4);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule